// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. A one-byte holding register sits in front of a frame shifter, so a host can hand over the next character while the current one is still on the line. The host presents a byte on `data_in` and pulses `load_n` low. The byte is captured while the strobe is low. On the strobe's return high it moves into the shifter at once if the line is idle. If a frame is still going out, the move is recorded as pending and happens on the very clock edge that ends the current stop bit. That edge starts the next start bit, so back-to-back frames leave no idle gap.

A frame is a low start bit, eight data bits least significant first, an optional even-parity bit, and a high stop bit. Each bit lasts sixteen pulses of the `baud_tick` enable. Two flags tell the host when it may write again (`hold_empty`) and when the line has fallen silent (`xmit_empty`). A third flag shows that a hand-off is waiting (`xfer_pending`).

Top module: `dbl_buf_tx`

## Requirements
- R1: During and right after reset, `ser_out` is 1, `hold_empty` and `xmit_empty` are 1, and `xfer_pending` is 0.
- R2: On every clock edge where `load_n` is low, `data_in` is written into the holding register and `hold_empty` goes to 0. The value captured at the last low edge is the one transmitted.
- R3: On the first edge where `load_n` is high after being low, with the line idle, the frame starts. After that edge `ser_out` is 0, `xmit_empty` is 0 and `hold_empty` is 1.
- R4: A frame is one start bit (0), then data bits 0 through 7 in that order, then one stop bit (1). The line idles at 1.
- R5: When `parity_en` is 1 at frame start, an extra bit equal to the XOR of the eight data bits (even parity) is sent between data bit 7 and the stop bit.
- R6: Each bit is held for exactly 16 `baud_tick` pulses. With `baud_tick` low, `ser_out` does not change during a frame.
- R7: A rising strobe edge while a frame is being sent sets `xfer_pending` to 1 and keeps `hold_empty` at 0. It does not disturb the frame in progress.
- R8: A pending byte moves into the shifter on the edge that ends the stop bit. After that edge `ser_out` is 0 (new start bit), `xfer_pending` is 0, `hold_empty` is 1, and `xmit_empty` stays 0.
- R9: When the stop bit ends with nothing pending, `xmit_empty` returns to 1 and `ser_out` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Bit-time enable, 16 pulses per bit |
| load_n | input | 1 | Active-low write strobe; its rising edge requests the hand-off |
| data_in | input | 8 | Byte to transmit |
| parity_en | input | 1 | Adds an even-parity bit to frames started while high |
| ser_out | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register may be written |
| xmit_empty | output | 1 | No frame is being shifted |
| xfer_pending | output | 1 | A hand-off is waiting for the current frame to end |

## Verification
The hardest corner is a strobe that arrives mid-frame. A design that transferred at once would corrupt the running frame. One that dropped the request would never send the second byte. One that waited an extra cycle would show a one-clock idle high and a brief `xmit_empty` between frames, and the bench samples exactly the ending edge to catch that. Tick gating is tested with the enable held low for many cycles, which exposes a counter running on the clock instead of the tick. The data bus is changed while the strobe is still low, so a design that latched on the falling edge sends the wrong byte. Parity frames are sent with both odd and even bit counts, and a wrong bit count shows up as a misplaced stop bit.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
    localparam int unsigned DBTX_DATA_W = 8;   // character width
    localparam int unsigned DBTX_OVS    = 16;  // baud ticks per bit

    // Number of bit slots in a frame: start + data + optional parity + stop
    function automatic int unsigned frame_slots(input int unsigned dw, input logic par);
        return dw + 2 + (par ? 1 : 0);
    endfunction
endpackage

// File: rtl/dbtx_strobe.sv
module dbtx_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    output logic capture,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = load_n;
        capture   = ~load_n;
        rise      = load_n & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dbtx_hold.sv
module dbtx_hold #(
    parameter int unsigned DW = dbtx_pkg::DBTX_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          rise,
    input  logic [DW-1:0] data_in,
    input  logic          ready,
    output logic          start,
    output logic [DW-1:0] hold_data,
    output logic          hold_empty,
    output logic          pending
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          empty;
        logic          pend;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d  = hd_q;
        start = 1'b0;
        if ((rise || hd_q.pend) && !hd_q.empty && ready) begin
            start      = 1'b1;
            hd_d.empty = 1'b1;
            hd_d.pend  = 1'b0;
        end else if (rise && !hd_q.empty) begin
            hd_d.pend  = 1'b1;
        end
        if (capture) begin
            hd_d.data  = data_in;
            hd_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '{data: '0, empty: 1'b1, pend: 1'b0};
        else        hd_q <= hd_d;
    end

    assign hold_data  = hd_q.data;
    assign hold_empty = hd_q.empty;
    assign pending    = hd_q.pend;

    AST_PEND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !hold_empty); // R7
endmodule

// File: rtl/dbtx_shift.sv
module dbtx_shift #(
    parameter int unsigned DW  = dbtx_pkg::DBTX_DATA_W,
    parameter int unsigned OVS = dbtx_pkg::DBTX_OVS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          par_en,
    output logic          ser_out,
    output logic          busy,
    output logic          ready,
    output logic          fin
);
    localparam int unsigned FW = DW + 3;
    localparam int unsigned BW = $clog2(FW + 1);
    localparam int unsigned TW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [TW-1:0] TCK_LAST = TW'(OVS - 1);

    typedef struct packed {
        logic          busy;
        logic [FW-1:0] sh;
        logic [BW-1:0] bidx;
        logic [BW-1:0] last;
        logic [TW-1:0] tck;
    } shift_t;

    shift_t sf_d, sf_q;
    logic   bit_end;

    always_comb begin
        sf_d    = sf_q;
        bit_end = sf_q.busy && baud_tick && (sf_q.tck == TCK_LAST);
        fin     = bit_end && (sf_q.bidx == sf_q.last);
        ready   = !sf_q.busy || fin;
        if (bit_end) begin
            sf_d.tck  = '0;
            sf_d.sh   = {1'b1, sf_q.sh[FW-1:1]};
            sf_d.bidx = sf_q.bidx + BW'(1);
            if (fin) sf_d.busy = 1'b0;
        end else if (sf_q.busy && baud_tick) begin
            sf_d.tck = sf_q.tck + TW'(1);
        end
        if (start) begin
            sf_d.busy = 1'b1;
            sf_d.tck  = '0;
            sf_d.bidx = '0;
            sf_d.last = BW'(dbtx_pkg::frame_slots(DW, par_en) - 1);
            sf_d.sh   = {1'b1, (par_en ? ^data : 1'b1), data, 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sf_q <= '{busy: 1'b0, sh: '1, bidx: '0, last: '0, tck: '0};
        else        sf_q <= sf_d;
    end

    assign ser_out = sf_q.sh[0];
    assign busy    = sf_q.busy;

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(ser_out)); // R6
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !start) |=> ser_out); // R9
endmodule

// File: rtl/dbl_buf_tx.sv
module dbl_buf_tx #(
    parameter int unsigned DATA_W = dbtx_pkg::DBTX_DATA_W,
    parameter int unsigned OVS    = dbtx_pkg::DBTX_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              load_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              parity_en,
    output logic              ser_out,
    output logic              hold_empty,
    output logic              xmit_empty,
    output logic              xfer_pending
);
    logic              capture, rise, start, ready, fin, busy;
    logic [DATA_W-1:0] hold_data;

    dbtx_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_n  (load_n),
        .capture (capture),
        .rise    (rise)
    );

    dbtx_hold #(.DW(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .rise       (rise),
        .data_in    (data_in),
        .ready      (ready),
        .start      (start),
        .hold_data  (hold_data),
        .hold_empty (hold_empty),
        .pending    (xfer_pending)
    );

    dbtx_shift #(.DW(DATA_W), .OVS(OVS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .start     (start),
        .data      (hold_data),
        .par_en    (parity_en),
        .ser_out   (ser_out),
        .busy      (busy),
        .ready     (ready),
        .fin       (fin)
    );

    assign xmit_empty = ~busy;

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xmit_empty) |-> !ser_out); // R4
    AST_PEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_pending) |-> !xmit_empty); // R7
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pending && fin) |=> (!xfer_pending && !xmit_empty && !ser_out && hold_empty)); // R8
endmodule

// File: tb/tb_dbl_buf_tx.sv
module tb_dbl_buf_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       load_n = 1'b1;
    logic [7:0] data_in = '0;
    logic       parity_en = 1'b0;
    logic       ser_out, hold_empty, xmit_empty, xfer_pending;

    int cyc = 0;
    int div_r = 1;
    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        @(negedge clk);
        baud_tick = (div_r != 0) && (cyc % div_r == 0);
    end

    dbl_buf_tx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load_n(load_n),
        .data_in(data_in), .parity_en(parity_en), .ser_out(ser_out),
        .hold_empty(hold_empty), .xmit_empty(xmit_empty), .xfer_pending(xfer_pending)
    );

    // {data[7:0], parity_en, slow_tick}
    localparam logic [9:0] VEC [8] = '{
        {8'h55, 1'b0, 1'b0}, {8'hA3, 1'b1, 1'b0}, {8'h00, 1'b1, 1'b0}, {8'hFF, 1'b0, 1'b1},
        {8'h81, 1'b1, 1'b1}, {8'h7E, 1'b0, 1'b0}, {8'h01, 1'b1, 1'b0}, {8'hC6, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic logic exp_bit(input logic [7:0] d, input logic p, input int k);
        if (k == 0) return 1'b0;
        if (k <= 8) return d[k-1];
        if (k == 9 && p) return ^d;
        return 1'b1;
    endfunction

    task automatic strobe(input logic [7:0] d);
        @(negedge clk); load_n = 1'b0; data_in = d;
        @(negedge clk);
        @(negedge clk); load_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic p, input int dv);
        int t0, per, nb;
        div_r = dv; per = 16 * dv; nb = p ? 11 : 10;
        @(negedge clk); parity_en = p; data_in = ~d; load_n = 1'b0;
        @(negedge clk); data_in = d;
        @(negedge clk);
        chk("R2 hold_empty after capture", hold_empty, 0);
        load_n = 1'b1;
        @(negedge clk);
        t0 = cyc;
        chk("R3 start bit", ser_out, 0);
        chk("R3 xmit_empty", xmit_empty, 0);
        chk("R3 hold_empty", hold_empty, 1);
        wait_until(t0 + per - 2);
        chk("R6 start bit held", ser_out, 0);
        for (int k = 1; k < nb; k++) begin
            wait_until(t0 + per * k + per / 2);
            chk((k == 9 && p) ? "R5 parity bit" : "R4 frame bit", ser_out, exp_bit(d, p, k));
        end
        wait_until(t0 + per * nb + 2);
        chk("R9 xmit_empty", xmit_empty, 1);
        chk("R9 idle line", ser_out, 1);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        chk("R1 ser_out", ser_out, 1);
        chk("R1 hold_empty", hold_empty, 1);
        chk("R1 xmit_empty", xmit_empty, 1);
        chk("R1 pending", xfer_pending, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset", {ser_out, hold_empty, xmit_empty, xfer_pending}, 4'b1110);

        for (int i = 0; i < 8; i++)
            run_frame(VEC[i][9:2], VEC[i][1], VEC[i][0] ? 2 : 1);

        // R6: no ticks, frame frozen
        div_r = 0; parity_en = 1'b0;
        strobe(8'h5A);
        t0 = cyc;
        chk("R6 start with no ticks", ser_out, 0);
        wait_until(t0 + 100);
        chk("R6 frozen line", ser_out, 0);
        chk("R6 still busy", xmit_empty, 0);
        div_r = 1;
        wait_until(t0 + 100 + 165);
        chk("R9 done after ticks resume", xmit_empty, 1);

        // R7/R8: deferred hand-off
        div_r = 1;
        strobe(8'h3C);
        t0 = cyc;
        wait_until(t0 + 40);
        strobe(8'hB5);
        chk("R7 pending set", xfer_pending, 1);
        chk("R7 hold full", hold_empty, 0);
        chk("R7 still busy", xmit_empty, 0);
        wait_until(t0 + 72);
        chk("R7 frame undisturbed", ser_out, exp_bit(8'h3C, 1'b0, 4));
        wait_until(t0 + 159);
        chk("R8 stop bit before hand-off", ser_out, 1);
        chk("R8 pending before hand-off", xfer_pending, 1);
        wait_until(t0 + 160);
        chk("R8 back-to-back start", ser_out, 0);
        chk("R8 pending cleared", xfer_pending, 0);
        chk("R8 hold emptied", hold_empty, 1);
        chk("R8 no idle gap", xmit_empty, 0);
        wait_until(t0 + 160 + 24);
        chk("R8 second byte bit0", ser_out, exp_bit(8'hB5, 1'b0, 1));
        wait_until(t0 + 320 + 2);
        chk("R9 empty after second frame", xmit_empty, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end
endmodule